// File: doc/BRIEF.md
# Router Mainboard I/O Controller

This block is the control and status register set of a modular router mainboard. It sits on a simple synchronous CPU register bus that has an address, separate read and write strobes, and write and read data. Software uses it for four things. It bit-bangs a serial EEPROM on the mainboard and a second EEPROM port that is shared by four module slots. It reads which slots are populated, what chassis it runs in and the environmental state. It keeps an 8-bit I/O mask. It acknowledges three interrupt lines.

Each interrupt output is a sticky level. A one-cycle event pulse sets it, and a read of its status register clears it. The network line is the exception: it clears only on every sixteenth access to its status window, so a burst of status polls does not drop an interrupt that is still pending. The module EEPROM port takes its slot number and its serial line levels from the same write. Only the selected slot sees the driven lines.

Top module: `rtr_io_ctrl`

## Requirements
- R1: A read of offset 0x00008 returns 0x00FF, and a read of offset 0x0000A returns 0x1000. Writes to either offset change nothing.
- R2: A write to offset 0x0000E latches mainboard chip select from bit 0, serial clock from bit 1 and data-in from bit 2. A read of that offset returns the mainboard data-out pin in bit 3, with every other bit zero.
- R3: A write to offset 0x10008 selects slot bits[1:0] and, in the same write, latches serial clock from bit 2, chip select from bit 4 and data-in from bit 6. The latched levels appear only on the selected slot's lines; all other slots' lines stay low.
- R4: A read of offset 0x10008 returns the selected slot's data-out pin in bit 7, with every other bit zero.
- R5: A read of offset 0x10006 returns 0xFFFF, except that for each populated slot i (0..3) the bits 0x1111<<i are zero.
- R6: A read of any offset from 0x20000 to 0x20003 returns 0x00FF. Every read or write there counts one access, and the sixteenth access since reset or since the last clear clears the network interrupt and restarts the count.
- R7: A read of offset 0x20004 returns 0 and clears the module-management interrupt. A read of offset 0x20006 returns 0 and clears the external interrupt.
- R8: Each interrupt output rises in the cycle after its event pulse and stays high until its clearing access. When a set and a clear fall in the same cycle, the output stays high.
- R9: Offset 0x20008 holds an 8-bit mask. A read returns the last written bits[7:0], zero-extended.
- R10: A read of offset 0x30000 returns a chassis code in bits[7:5], with all other bits zero. The code is 0 for configuration 0 (four-slot), 4 for configuration 1 (two-slot), 3 for configuration 2 (six-slot) and 0 for configuration 3.
- R11: A read of offset 0x30004 returns 0x0021 (no overtemperature, input voltage good).
- R12: Read data is registered. It is valid the cycle after the read strobe and holds until the next read. Unmapped offsets read zero and ignore writes.
- R13: After reset the read data, the mask, the slot select, the access count, every EEPROM line and every interrupt output are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_chassis | input | 2 | Static chassis configuration (0 four-slot, 1 two-slot, 2 six-slot) |
| bus_addr | input | 18 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| mb_ee_cs | output | 1 | Mainboard EEPROM chip select |
| mb_ee_sk | output | 1 | Mainboard EEPROM serial clock |
| mb_ee_di | output | 1 | Mainboard EEPROM data-in |
| mb_ee_do | input | 1 | Mainboard EEPROM data-out |
| nm_ee_cs | output | 4 | Per-slot module EEPROM chip select |
| nm_ee_sk | output | 4 | Per-slot module EEPROM serial clock |
| nm_ee_di | output | 4 | Per-slot module EEPROM data-in |
| nm_ee_do | input | 4 | Per-slot module EEPROM data-out |
| slot_present | input | 4 | Per-slot presence, high when populated |
| net_evt | input | 1 | Network interrupt event pulse |
| mgmt_evt | input | 1 | Module-management interrupt event pulse |
| ext_evt | input | 1 | External interrupt event pulse |
| net_irq | output | 1 | Network interrupt level |
| mgmt_irq | output | 1 | Module-management interrupt level |
| ext_irq | output | 1 | External interrupt level |

## Verification
An interrupt's event pulse can arrive in the same cycle as the bus access that clears that interrupt. For the network line, that access is the sixteenth status access. The bench drives event pulses at random alongside random bus traffic over every mapped offset, and it steers a directed case so that a network event lands exactly on the sixteenth access. A reference model in the bench applies the clear first and then the set. It compares all three interrupt levels after every cycle, so an output must stay high whenever the two collide, and the access count must still restart.

// File: rtl/rtr_io_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the router I/O controller.
// Assumes an 18-bit byte offset bus and 16-bit data.
package rtr_io_pkg;

    localparam int unsigned BUS_AW = 18;
    localparam int unsigned BUS_DW = 16;

    // Register offsets
    localparam logic [BUS_AW-1:0] A_FLASH_WP = 18'h00008;
    localparam logic [BUS_AW-1:0] A_BOOT_SZ  = 18'h0000A;
    localparam logic [BUS_AW-1:0] A_MB_EE    = 18'h0000E;
    localparam logic [BUS_AW-1:0] A_PRESENCE = 18'h10006;
    localparam logic [BUS_AW-1:0] A_NM_EE    = 18'h10008;
    localparam logic [BUS_AW-1:0] A_NET_BASE = 18'h20000;
    localparam logic [BUS_AW-1:0] A_MGMT     = 18'h20004;
    localparam logic [BUS_AW-1:0] A_EXT      = 18'h20006;
    localparam logic [BUS_AW-1:0] A_IOMASK   = 18'h20008;
    localparam logic [BUS_AW-1:0] A_CHASSIS  = 18'h30000;
    localparam logic [BUS_AW-1:0] A_ENV      = 18'h30004;

    // Fixed read values
    localparam logic [BUS_DW-1:0] V_FLASH_WP = 16'h00FF;
    localparam logic [BUS_DW-1:0] V_BOOT_SZ  = 16'h1000;
    localparam logic [BUS_DW-1:0] V_NET_STAT = 16'h00FF;
    localparam logic [BUS_DW-1:0] V_ENV_OK   = 16'h0021;

    // Static chassis configuration
    typedef enum logic [1:0] {
        CHS_FOUR_SLOT = 2'd0,
        CHS_TWO_SLOT  = 2'd1,
        CHS_SIX_SLOT  = 2'd2,
        CHS_UNKNOWN   = 2'd3
    } chassis_e;

    // Maps the chassis configuration to the 3-bit identification code.
    function automatic logic [2:0] chassis_code(input chassis_e c);
        case (c)
            CHS_TWO_SLOT: return 3'd4;
            CHS_SIX_SLOT: return 3'd3;
            default:      return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/rtr_io_eeprom.sv
`timescale 1ns/1ps
// Bit-banged serial EEPROM ports: one mainboard port and one port
// shared across NUM_SLOTS module slots. Write strobes are pre-decoded
// by the parent; wbyte is the low byte of the bus write data.
// Assumes NUM_SLOTS <= 4, so the slot select fits in bits[1:0].
module rtr_io_eeprom #(
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mb_wr,
    input  logic                 nm_wr,
    input  logic [7:0]           wbyte,
    input  logic                 mb_ee_do,
    input  logic [NUM_SLOTS-1:0] nm_ee_do,
    output logic                 mb_ee_cs,
    output logic                 mb_ee_sk,
    output logic                 mb_ee_di,
    output logic [NUM_SLOTS-1:0] nm_ee_cs,
    output logic [NUM_SLOTS-1:0] nm_ee_sk,
    output logic [NUM_SLOTS-1:0] nm_ee_di,
    output logic                 mb_rbit,
    output logic                 nm_rbit
);

    localparam int unsigned SEL_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;
    localparam int unsigned MB_CS_B = 0;
    localparam int unsigned MB_SK_B = 1;
    localparam int unsigned MB_DI_B = 2;
    localparam int unsigned NM_SK_B = 2;
    localparam int unsigned NM_CS_B = 4;
    localparam int unsigned NM_DI_B = 6;

    logic [SEL_W-1:0] sel_q;
    logic             nm_cs_q, nm_sk_q, nm_di_q;
    logic             unused_bits;

    assign unused_bits = ^{wbyte[7], wbyte[5], wbyte[3]};

    // Latch the mainboard line levels on a write to its register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mb_ee_cs <= 1'b0;
            mb_ee_sk <= 1'b0;
            mb_ee_di <= 1'b0;
        end else if (mb_wr) begin
            mb_ee_cs <= wbyte[MB_CS_B];
            mb_ee_sk <= wbyte[MB_SK_B];
            mb_ee_di <= wbyte[MB_DI_B];
        end
    end

    // Latch the slot select and module line levels from one write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q   <= '0;
            nm_cs_q <= 1'b0;
            nm_sk_q <= 1'b0;
            nm_di_q <= 1'b0;
        end else if (nm_wr) begin
            sel_q   <= wbyte[SEL_W-1:0];
            nm_cs_q <= wbyte[NM_CS_B];
            nm_sk_q <= wbyte[NM_SK_B];
            nm_di_q <= wbyte[NM_DI_B];
        end
    end

    // Route the latched levels to the selected slot only.
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        logic hit;
        assign hit         = (sel_q == SEL_W'(s));
        assign nm_ee_cs[s] = hit & nm_cs_q;
        assign nm_ee_sk[s] = hit & nm_sk_q;
        assign nm_ee_di[s] = hit & nm_di_q;
    end

    // Return the data-out pins for readback.
    always_comb begin
        mb_rbit = mb_ee_do;
        nm_rbit = nm_ee_do[sel_q];
    end

    // R3: a module write drives chip select onto the written slot only
    p_nm_cs_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
        nm_wr |=> (nm_ee_cs == ($past(wbyte[NM_CS_B]) ?
                   (NUM_SLOTS'(1) << $past(wbyte[SEL_W-1:0])) : NUM_SLOTS'(0))));

    // R3: at most one slot's chip select is ever high
    p_nm_cs_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(nm_ee_cs));

    // R2: mainboard lines move only on a mainboard write
    p_mb_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !mb_wr |=> $stable({mb_ee_cs, mb_ee_sk, mb_ee_di}));

endmodule

// File: rtl/rtr_io_status.sv
`timescale 1ns/1ps
// Combinational status words: slot presence, chassis identification
// and environmental state. Presence inputs are active high; the
// returned word is active low and repeats the slot pattern across
// every NUM_SLOTS-bit group of the data word.
module rtr_io_status
    import rtr_io_pkg::*;
#(
    parameter int unsigned DATA_W    = BUS_DW,
    parameter int unsigned NUM_SLOTS = 4
) (
    input  logic [NUM_SLOTS-1:0] slot_present,
    input  logic [1:0]           cfg_chassis,
    output logic [DATA_W-1:0]    presence_word,
    output logic [DATA_W-1:0]    chassis_word,
    output logic [DATA_W-1:0]    env_word
);

    localparam int unsigned CODE_LSB = 5;

    // Each presence bit reflects the slot given by its position modulo NUM_SLOTS.
    for (genvar b = 0; b < DATA_W; b++) begin : g_pres
        assign presence_word[b] = ~slot_present[b % NUM_SLOTS];
    end

    // Place the chassis code in bits [7:5].
    always_comb begin
        chassis_word = '0;
        chassis_word[CODE_LSB +: 3] = chassis_code(chassis_e'(cfg_chassis));
    end

    // Normal environmental conditions.
    assign env_word = DATA_W'(V_ENV_OK);

endmodule

// File: rtl/rtr_io_irq.sv
`timescale 1ns/1ps
// One sticky interrupt level. A set pulse raises it; a clearing access
// lowers it. With CLR_COUNT > 1 only every CLR_COUNT-th access clears.
// A set in the same cycle as a clear wins.
module rtr_io_irq #(
    parameter int unsigned CLR_COUNT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_acc,
    output logic irq_o
);

    logic clr_now;

    if (CLR_COUNT > 1) begin : g_counted
        localparam int unsigned CNT_W = $clog2(CLR_COUNT);
        localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLR_COUNT - 1);
        logic [CNT_W-1:0] cnt_q;

        // Count clearing accesses, restarting after the last one.
        always_ff @(posedge clk) begin
            if (!rst_n)              cnt_q <= '0;
            else if (clr_acc) begin
                if (cnt_q == CNT_LAST) cnt_q <= '0;
                else                   cnt_q <= cnt_q + 1'b1;
            end
        end

        assign clr_now = clr_acc && (cnt_q == CNT_LAST);

        // R6: the count moves only on a status access
        p_cnt_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !clr_acc |=> $stable(cnt_q));

        // R6: a clear always leaves the count at zero
        p_cnt_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
            clr_now |=> (cnt_q == '0));
    end else begin : g_direct
        assign clr_now = clr_acc;
    end

    // Hold the interrupt level; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq_o <= 1'b0;
        else if (set_evt) irq_o <= 1'b1;
        else if (clr_now) irq_o <= 1'b0;
    end

    // R8: an event always raises the line in the next cycle
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> irq_o);

    // R8: the line falls only after a clear
    p_fall_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_o) |-> $past(clr_now));

    // R8: the line never rises without an event
    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !set_evt) |=> !irq_o);

endmodule

// File: rtl/rtr_io_ctrl.sv
`timescale 1ns/1ps
// Router I/O controller register block. Decodes the CPU register bus,
// registers read data one cycle after the read strobe and instantiates
// the EEPROM ports, status words and the three interrupt levels.
// Assumes read and write strobes are never high together.
module rtr_io_ctrl
    import rtr_io_pkg::*;
#(
    parameter int unsigned ADDR_W        = BUS_AW,
    parameter int unsigned DATA_W        = BUS_DW,
    parameter int unsigned NUM_SLOTS     = 4,
    parameter int unsigned MASK_W        = 8,
    parameter int unsigned NET_CLR_COUNT = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_chassis,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 mb_ee_cs,
    output logic                 mb_ee_sk,
    output logic                 mb_ee_di,
    input  logic                 mb_ee_do,
    output logic [NUM_SLOTS-1:0] nm_ee_cs,
    output logic [NUM_SLOTS-1:0] nm_ee_sk,
    output logic [NUM_SLOTS-1:0] nm_ee_di,
    input  logic [NUM_SLOTS-1:0] nm_ee_do,
    input  logic [NUM_SLOTS-1:0] slot_present,
    input  logic                 net_evt,
    input  logic                 mgmt_evt,
    input  logic                 ext_evt,
    output logic                 net_irq,
    output logic                 mgmt_irq,
    output logic                 ext_irq
);

    localparam int unsigned MB_DO_B = 3;
    localparam int unsigned NM_DO_B = 7;
    localparam int unsigned NET_LSB = 2;

    logic                 acc;
    logic                 hit_mb, hit_nm, hit_net, hit_mgmt, hit_ext, hit_mask;
    logic                 mb_rbit, nm_rbit;
    logic [DATA_W-1:0]    presence_word, chassis_word, env_word;
    logic [DATA_W-1:0]    rd_mux;
    logic [MASK_W-1:0]    mask_q;
    logic                 unused_wdata;

    assign unused_wdata = ^bus_wdata[DATA_W-1:MASK_W];

    // Offset decode shared by read, write and interrupt logic.
    always_comb begin
        acc      = bus_rd | bus_wr;
        hit_mb   = (bus_addr == A_MB_EE);
        hit_nm   = (bus_addr == A_NM_EE);
        hit_net  = (bus_addr[ADDR_W-1:NET_LSB] == A_NET_BASE[ADDR_W-1:NET_LSB]);
        hit_mgmt = (bus_addr == A_MGMT);
        hit_ext  = (bus_addr == A_EXT);
        hit_mask = (bus_addr == A_IOMASK);
    end

    rtr_io_eeprom #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_eeprom (
        .clk      (clk),
        .rst_n    (rst_n),
        .mb_wr    (bus_wr & hit_mb),
        .nm_wr    (bus_wr & hit_nm),
        .wbyte    (bus_wdata[7:0]),
        .mb_ee_do (mb_ee_do),
        .nm_ee_do (nm_ee_do),
        .mb_ee_cs (mb_ee_cs),
        .mb_ee_sk (mb_ee_sk),
        .mb_ee_di (mb_ee_di),
        .nm_ee_cs (nm_ee_cs),
        .nm_ee_sk (nm_ee_sk),
        .nm_ee_di (nm_ee_di),
        .mb_rbit  (mb_rbit),
        .nm_rbit  (nm_rbit)
    );

    rtr_io_status #(
        .DATA_W    (DATA_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_status (
        .slot_present  (slot_present),
        .cfg_chassis   (cfg_chassis),
        .presence_word (presence_word),
        .chassis_word  (chassis_word),
        .env_word      (env_word)
    );

    rtr_io_irq #(.CLR_COUNT(NET_CLR_COUNT)) u_irq_net (
        .clk (clk), .rst_n (rst_n), .set_evt (net_evt),
        .clr_acc (acc & hit_net), .irq_o (net_irq)
    );

    rtr_io_irq #(.CLR_COUNT(1)) u_irq_mgmt (
        .clk (clk), .rst_n (rst_n), .set_evt (mgmt_evt),
        .clr_acc (bus_rd & hit_mgmt), .irq_o (mgmt_irq)
    );

    rtr_io_irq #(.CLR_COUNT(1)) u_irq_ext (
        .clk (clk), .rst_n (rst_n), .set_evt (ext_evt),
        .clr_acc (bus_rd & hit_ext), .irq_o (ext_irq)
    );

    // I/O mask register written from the low data bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mask_q <= '0;
        else if (bus_wr && hit_mask) mask_q <= bus_wdata[MASK_W-1:0];
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        rd_mux = '0;
        if (hit_net) begin
            rd_mux = DATA_W'(V_NET_STAT);
        end else begin
            case (bus_addr)
                A_FLASH_WP: rd_mux = DATA_W'(V_FLASH_WP);
                A_BOOT_SZ:  rd_mux = DATA_W'(V_BOOT_SZ);
                A_MB_EE:    rd_mux[MB_DO_B] = mb_rbit;
                A_PRESENCE: rd_mux = presence_word;
                A_NM_EE:    rd_mux[NM_DO_B] = nm_rbit;
                A_IOMASK:   rd_mux[MASK_W-1:0] = mask_q;
                A_CHASSIS:  rd_mux = chassis_word;
                A_ENV:      rd_mux = env_word;
                default:    rd_mux = '0;
            endcase
        end
    end

    // Capture read data on the read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // R12: read and write strobes are exclusive
    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    // R12: read data holds between reads
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R11: an environmental read returns the normal word one cycle later
    p_env_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == A_ENV) |=> (bus_rdata == DATA_W'(V_ENV_OK)));

    // R7: a management status read returns zero
    p_mgmt_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && hit_mgmt) |=> (bus_rdata == '0));

endmodule

// File: tb/rtr_io_ctrl_tb.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random traffic,
// compared every cycle against a bench reference model.
module rtr_io_ctrl_tb;
    import rtr_io_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  cfg_chassis;
    logic [17:0] bus_addr;
    logic        bus_wr, bus_rd;
    logic [15:0] bus_wdata, bus_rdata;
    logic        mb_ee_cs, mb_ee_sk, mb_ee_di, mb_ee_do;
    logic [3:0]  nm_ee_cs, nm_ee_sk, nm_ee_di, nm_ee_do, slot_present;
    logic        net_evt, mgmt_evt, ext_evt;
    logic        net_irq, mgmt_irq, ext_irq;

    always #2.5 clk = ~clk;

    rtr_io_ctrl u_dut (
        .clk (clk), .rst_n (rst_n), .cfg_chassis (cfg_chassis),
        .bus_addr (bus_addr), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
        .mb_ee_cs (mb_ee_cs), .mb_ee_sk (mb_ee_sk), .mb_ee_di (mb_ee_di),
        .mb_ee_do (mb_ee_do), .nm_ee_cs (nm_ee_cs), .nm_ee_sk (nm_ee_sk),
        .nm_ee_di (nm_ee_di), .nm_ee_do (nm_ee_do), .slot_present (slot_present),
        .net_evt (net_evt), .mgmt_evt (mgmt_evt), .ext_evt (ext_evt),
        .net_irq (net_irq), .mgmt_irq (mgmt_irq), .ext_irq (ext_irq)
    );

    int n_chk = 0;
    int n_bad = 0;

    // Reference model state
    logic [7:0]  m_mask;
    logic [2:0]  m_mb;     // {cs, sk, di}
    logic [1:0]  m_sel;
    logic [2:0]  m_nm;     // {cs, sk, di}
    int          m_cnt;
    logic [2:0]  m_irq;    // {ext, mgmt, net}
    logic [15:0] m_rdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_read(input logic [17:0] a);
        logic [15:0] r;
        r = 16'h0;
        if (a[17:2] == 16'h8000) r = 16'h00FF;              // R6
        else case (a)
            18'h00008: r = 16'h00FF;                          // R1
            18'h0000A: r = 16'h1000;                          // R1
            18'h0000E: r[3] = mb_ee_do;                       // R2
            18'h10006: for (int b = 0; b < 16; b++)           // R5
                           r[b] = ~slot_present[b % 4];
            18'h10008: r[7] = nm_ee_do[m_sel];                // R4
            18'h20008: r = {8'h00, m_mask};                   // R9
            18'h30000: case (cfg_chassis)                     // R10
                           2'd1: r = 16'h0080;
                           2'd2: r = 16'h0060;
                           default: r = 16'h0000;
                       endcase
            18'h30004: r = 16'h0021;                          // R11
            default:   r = 16'h0000;                          // R7, R12
        endcase
        return r;
    endfunction

    function automatic string req_of(input logic [17:0] a);
        if (a[17:2] == 16'h8000) return "R6";
        case (a)
            18'h00008, 18'h0000A: return "R1";
            18'h0000E: return "R2";
            18'h10006: return "R5";
            18'h10008: return "R4";
            18'h20004, 18'h20006: return "R7";
            18'h20008: return "R9";
            18'h30000: return "R10";
            18'h30004: return "R11";
            default:   return "R12";
        endcase
    endfunction

    // One bus cycle: drive at a falling edge, update model, check after next falling edge.
    task automatic step(input logic [17:0] a, input logic rd, input logic wr,
                        input logic [15:0] wd, input logic [2:0] ev);
        string rq;
        logic  net_clr;
        bus_addr = a; bus_rd = rd; bus_wr = wr; bus_wdata = wd;
        {ext_evt, mgmt_evt, net_evt} = ev;
        rq = "R12";
        if (rd) begin m_rdata = exp_read(a); rq = req_of(a); end
        net_clr = 1'b0;
        if ((rd || wr) && a[17:2] == 16'h8000) begin
            if (m_cnt == 15) begin m_cnt = 0; net_clr = 1'b1; end
            else m_cnt++;
        end
        m_irq[0] = ev[0] | (m_irq[0] & ~net_clr);
        m_irq[1] = ev[1] | (m_irq[1] & ~(rd && a == 18'h20004));
        m_irq[2] = ev[2] | (m_irq[2] & ~(rd && a == 18'h20006));
        if (wr) begin
            case (a)
                18'h0000E: m_mb = {wd[0], wd[1], wd[2]};
                18'h10008: begin m_sel = wd[1:0]; m_nm = {wd[4], wd[2], wd[6]}; end
                18'h20008: m_mask = wd[7:0];
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; {ext_evt, mgmt_evt, net_evt} = 3'b000;
        chk(rq, {16'h0, bus_rdata}, {16'h0, m_rdata});
        chk("R6 R7 R8 irq", {29'h0, ext_irq, mgmt_irq, net_irq}, {29'h0, m_irq});
        chk("R2 lines", {29'h0, mb_ee_cs, mb_ee_sk, mb_ee_di}, {29'h0, m_mb});
        chk("R3 lines", {20'h0, nm_ee_cs, nm_ee_sk, nm_ee_di},
            {20'h0, (4'b1 << m_sel) & {4{m_nm[2]}},
                    (4'b1 << m_sel) & {4{m_nm[1]}},
                    (4'b1 << m_sel) & {4{m_nm[0]}}});
    endtask

    task automatic rd(input logic [17:0] a);
        step(a, 1'b1, 1'b0, 16'h0, 3'b000);
    endtask

    task automatic wr(input logic [17:0] a, input logic [15:0] d);
        step(a, 1'b0, 1'b1, d, 3'b000);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [17:0] addrs [15];
        void'($urandom(32'd20240611));
        addrs = '{18'h00008, 18'h0000A, 18'h0000E, 18'h10006, 18'h10008,
                  18'h20000, 18'h20001, 18'h20002, 18'h20003, 18'h20004,
                  18'h20006, 18'h20008, 18'h30000, 18'h30004, 18'h00000};
        rst_n = 1'b0; cfg_chassis = 2'd0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_wdata = '0; mb_ee_do = 1'b0; nm_ee_do = '0; slot_present = '0;
        net_evt = 1'b0; mgmt_evt = 1'b0; ext_evt = 1'b0;
        m_mask = '0; m_mb = '0; m_sel = '0; m_nm = '0; m_cnt = 0; m_irq = '0; m_rdata = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R13: reset state at the ports
        chk("R13 rdata", {16'h0, bus_rdata}, 32'h0);
        chk("R13 irq", {29'h0, ext_irq, mgmt_irq, net_irq}, 32'h0);
        chk("R13 lines", {17'h0, mb_ee_cs, mb_ee_sk, mb_ee_di, nm_ee_cs, nm_ee_sk, nm_ee_di}, 32'h0);
        rd(18'h20008);                      // R13: mask reads zero
        rd(18'h10008);                      // R13: slot 0 selected

        // R1: fixed values, writes ignored
        wr(18'h00008, 16'h0000); wr(18'h0000A, 16'hFFFF);
        rd(18'h00008); rd(18'h0000A);

        // R2: mainboard lines and readback
        wr(18'h0000E, 16'h0005); mb_ee_do = 1'b1; rd(18'h0000E);
        mb_ee_do = 1'b0; rd(18'h0000E); wr(18'h0000E, 16'h000A);

        // R3 R4: slot select and lines from one write
        wr(18'h10008, 16'h0056); nm_ee_do = 4'b0100; rd(18'h10008);
        nm_ee_do = 4'b1011; rd(18'h10008);
        wr(18'h10008, 16'h0013); nm_ee_do = 4'b1000; rd(18'h10008);

        // R5: presence patterns
        slot_present = 4'b0101; rd(18'h10006);
        slot_present = 4'b1111; rd(18'h10006);
        slot_present = 4'b0000; rd(18'h10006);

        // R6: sixteenth access clears the network line
        step(18'h20008, 1'b1, 1'b0, 16'h0, 3'b001);
        for (int i = 0; i < 15; i++) rd(18'h20000 + 18'(i % 4));
        wr(18'h20002, 16'h1234);            // 16th access: clears
        // R8: set lands on the clearing access (16th again)
        step(18'h20008, 1'b1, 1'b0, 16'h0, 3'b001);
        for (int i = 0; i < 15; i++) rd(18'h20001);
        step(18'h20003, 1'b1, 1'b0, 16'h0, 3'b001);
        for (int i = 0; i < 16; i++) rd(18'h20000);

        // R7 R8: read-to-clear lines and set-wins
        step(18'h30004, 1'b1, 1'b0, 16'h0, 3'b110);
        rd(18'h20004); rd(18'h20006);
        step(18'h20004, 1'b1, 1'b0, 16'h0, 3'b010);
        wr(18'h20006, 16'h0); rd(18'h20004);

        // R9: mask readback
        wr(18'h20008, 16'h00A5); rd(18'h20008);
        wr(18'h20008, 16'h1234); rd(18'h20008);

        // R10 R11: chassis codes and environment
        for (int c = 0; c < 4; c++) begin cfg_chassis = 2'(c); rd(18'h30000); end
        rd(18'h30004);

        // R12: unmapped reads zero and writes ignored
        wr(18'h3F010, 16'hFFFF); rd(18'h3F010); rd(18'h20008);

        // Random traffic with interleaved events
        for (int n = 0; n < 4000; n++) begin
            logic [17:0] a;
            int          op;
            logic [2:0]  ev;
            if (n % 50 == 0) begin
                slot_present = 4'($urandom); nm_ee_do = 4'($urandom);
                mb_ee_do = 1'($urandom); cfg_chassis = 2'($urandom);
            end
            op = $urandom_range(0, 14);
            a  = (op == 14) ? (18'h3F000 + 18'($urandom_range(0, 255))) : addrs[op];
            ev = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b000;
            case ($urandom_range(0, 2))
                0: step(a, 1'b1, 1'b0, 16'h0, ev);
                1: step(a, 1'b0, 1'b1, 16'($urandom), ev);
                default: step(a, 1'b0, 1'b0, 16'h0, ev);
            endcase
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule